// File: doc/BRIEF.md
# Programmable Coincidence Matrix with Event Scalers

This block takes sixteen discriminator-level logic inputs and turns them into eight programmable logic outputs. Each output has its own selection of inputs for an AND term and its own selection for an OR term. The output is the AND term ORed with the OR term, and a per-output invert bit can then flip the result. With these settings, one output can stand for a coincidence such as "input 2 and input 5 and input 9", for "any of inputs 0 to 3", or for the negation of either. Input synchronisation is done upstream, so the inputs reach the block already in the clock domain. The block registers each output once.

Every output drives its own event scaler. The scaler counts rising edges of the registered output while a shared count gate is high. A simple synchronous register bus writes and reads back all selection masks and the invert register, and it reads the scalers. A write to a control location clears all scalers at once. After reset every register is zero, so every output is low and every scaler reads zero.

Top module: `plu_scaler`

## Requirements
- R1: After reset, every mask, the invert register and every scaler read as zero, and `out_sig` is all zeros.
- R2: The AND term of output k is 1 when every input selected by AND mask k (address k, bit j = input j) is high. An all-zero AND mask gives an AND term of 0.
- R3: The OR term of output k is 1 when at least one input selected by OR mask k (address 8+k, bit j = input j) is high.
- R4: Before inversion, output k is its AND term ORed with its OR term. Either term alone can drive the output high.
- R5: Bit k of the invert register (address 16) inverts output k.
- R6: AND masks, OR masks and the invert register read back what was written. Only their low 16 bits (masks) or low 8 bits (invert) are stored, and the upper read bits are 0. Read data appears on `bus_rdata` one clock after `bus_addr` is presented.
- R7: Scaler k (read at address 24+k) increases by exactly one for each rising edge of `out_sig[k]` while `gate` is high. An output held high counts once, and the other scalers are unaffected.
- R8: While `gate` is low, rising edges of the outputs leave the scalers unchanged, and counting resumes when `gate` returns high.
- R9: Writing 1 in bit 0 at the control address 17 clears all scalers in that cycle. If a counted edge arrives in the same cycle, the clear takes priority.
- R10: Scalers wrap modulo 2^CNT_W (32 by default) with no saturation.
- R11: `out_sig` is registered: it reflects the inputs and configuration one clock after they are applied.
- R12: Writes to scaler addresses have no effect on the scaler values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_sig | input | 16 | Discriminator logic inputs, already synchronous |
| gate | input | 1 | Count gate for all scalers |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| out_sig | output | 8 | Registered matrix outputs |

## Verification
The hardest case to reach from the ports is the wrap of a scaler, because a 32-bit count needs over four billion edges. The bench therefore adds a second instance built with a 4-bit scaler width on the same buses. It drives seventeen pulses and expects 17 on the full instance and 1 on the narrow one. The second hardest case is a clear that lands in the very cycle a counted edge would register. The bench raises the input two cycles ahead so that the output edge and the control write meet at the same clock.

// File: rtl/plu_pkg.sv
package plu_pkg;

  // Address layout is derived from the output count:
  //   [0, N)        AND masks
  //   [N, 2N)       OR masks
  //   2N            invert register
  //   2N+1          control (bit 0 = clear scalers)
  //   [3N, 4N)      scalers
  function automatic int and_addr(input int n_out, input int k);
    return k;
  endfunction

  function automatic int or_addr(input int n_out, input int k);
    return n_out + k;
  endfunction

  function automatic int inv_addr(input int n_out);
    return 2 * n_out;
  endfunction

  function automatic int ctrl_addr(input int n_out);
    return 2 * n_out + 1;
  endfunction

  function automatic int cnt_addr(input int n_out, input int k);
    return 3 * n_out + k;
  endfunction

  localparam int CTRL_CLR_BIT = 0;

endpackage

// File: rtl/plu_regs.sv
module plu_regs
  import plu_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wr,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [NUM_OUT-1:0][NUM_IN-1:0]   and_mask,
  output logic [NUM_OUT-1:0][NUM_IN-1:0]   or_mask,
  output logic [NUM_OUT-1:0]               inv_mask,
  output logic                             clr_pulse
);

  logic [NUM_OUT-1:0][NUM_IN-1:0] and_q, and_d;
  logic [NUM_OUT-1:0][NUM_IN-1:0] or_q, or_d;
  logic [NUM_OUT-1:0]             inv_q, inv_d;
  logic                           cfg_en;

  // next-state: decode the write address against each location
  always_comb begin
    and_d = and_q;
    or_d  = or_q;
    inv_d = inv_q;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (bus_addr == ADDR_W'(and_addr(NUM_OUT, k)))
        and_d[k] = bus_wdata[NUM_IN-1:0];
      if (bus_addr == ADDR_W'(or_addr(NUM_OUT, k)))
        or_d[k] = bus_wdata[NUM_IN-1:0];
    end
    if (bus_addr == ADDR_W'(inv_addr(NUM_OUT)))
      inv_d = bus_wdata[NUM_OUT-1:0];
  end

  assign cfg_en = bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_q <= '0;
      or_q  <= '0;
      inv_q <= '0;
    end else if (cfg_en) begin
      and_q <= and_d;
      or_q  <= or_d;
      inv_q <= inv_d;
    end
  end

  assign clr_pulse = bus_wr
                   && (bus_addr == ADDR_W'(ctrl_addr(NUM_OUT)))
                   && bus_wdata[CTRL_CLR_BIT];

  assign and_mask = and_q;
  assign or_mask  = or_q;
  assign inv_mask = inv_q;

endmodule

// File: rtl/plu_matrix.sv
module plu_matrix #(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IN-1:0]              in_sig,
  input  logic [NUM_OUT-1:0][NUM_IN-1:0] and_mask,
  input  logic [NUM_OUT-1:0][NUM_IN-1:0] or_mask,
  input  logic [NUM_OUT-1:0]             inv_mask,
  output logic [NUM_OUT-1:0]             out_q
);

  logic [NUM_OUT-1:0] out_d;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_term
    logic and_sel_any;
    logic and_all_hit;
    logic and_term;
    logic or_term;

    always_comb begin
      and_sel_any = |and_mask[k];
      and_all_hit = ((in_sig & and_mask[k]) == and_mask[k]);
      and_term    = and_sel_any & and_all_hit;
      or_term     = |(in_sig & or_mask[k]);
      out_d[k]    = (and_term | or_term) ^ inv_mask[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/plu_counters.sv
module plu_counters #(
  parameter int NUM_OUT = 8,
  parameter int CNT_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_OUT-1:0]            lvl,
  input  logic                          gate,
  input  logic                          clr,
  output logic [NUM_OUT-1:0][CNT_W-1:0] cnt
);

  logic [NUM_OUT-1:0] prev_q;
  logic [NUM_OUT-1:0] rise;

  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = clr | (gate & rise[k]);
      if (clr) cnt_d = '0;
      else     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign cnt[k] = cnt_q;
  end

endmodule

// File: rtl/plu_scaler.sv
module plu_scaler
  import plu_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(4 * NUM_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] in_sig,
  input  logic              gate,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_OUT-1:0] out_sig
);

  logic                           rst_meta_q;
  logic                           rst_sync_n;
  logic [NUM_OUT-1:0][NUM_IN-1:0] and_mask;
  logic [NUM_OUT-1:0][NUM_IN-1:0] or_mask;
  logic [NUM_OUT-1:0]             inv_mask;
  logic                           clr_pulse;
  logic [NUM_OUT-1:0][CNT_W-1:0]  cnt_arr;
  logic [DATA_W-1:0]              rdata_d, rdata_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  plu_regs #(
    .NUM_IN (NUM_IN),
    .NUM_OUT(NUM_OUT),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .and_mask (and_mask),
    .or_mask  (or_mask),
    .inv_mask (inv_mask),
    .clr_pulse(clr_pulse)
  );

  plu_matrix #(
    .NUM_IN (NUM_IN),
    .NUM_OUT(NUM_OUT)
  ) u_matrix (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_sig  (in_sig),
    .and_mask(and_mask),
    .or_mask (or_mask),
    .inv_mask(inv_mask),
    .out_q   (out_sig)
  );

  plu_counters #(
    .NUM_OUT(NUM_OUT),
    .CNT_W  (CNT_W)
  ) u_counters (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .lvl  (out_sig),
    .gate (gate),
    .clr  (clr_pulse),
    .cnt  (cnt_arr)
  );

  // read mux, registered: data for bus_addr appears one clock later
  always_comb begin
    rdata_d = '0;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (bus_addr == ADDR_W'(and_addr(NUM_OUT, k)))
        rdata_d = DATA_W'(and_mask[k]);
      if (bus_addr == ADDR_W'(or_addr(NUM_OUT, k)))
        rdata_d = DATA_W'(or_mask[k]);
      if (bus_addr == ADDR_W'(cnt_addr(NUM_OUT, k)))
        rdata_d = DATA_W'(cnt_arr[k]);
    end
    if (bus_addr == ADDR_W'(inv_addr(NUM_OUT)))
      rdata_d = DATA_W'(inv_mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/plu_scaler_chk.sv
module plu_scaler_chk #(
  parameter int NUM_OUT = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          gate,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [NUM_OUT-1:0]            out_sig,
  input logic [NUM_OUT-1:0][CNT_W-1:0] cnt
);

  logic clr_req;
  assign clr_req = bus_wr && (bus_addr == ADDR_W'(2 * NUM_OUT + 1)) && bus_wdata[0];

  // R9: a clear request leaves every scaler at zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (cnt == '0));

  // R8: with the gate low and no clear, no scaler moves
  a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !clr_req) |=> $stable(cnt));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R10 / R12: a scaler moves by at most one per clock, wrapping
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> ((cnt[k] == $past(cnt[k])) ||
                    (cnt[k] == CNT_W'($past(cnt[k]) + 1'b1))));

    // R7: an increment needs a gated rising edge of the output
    a_r7_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> ((cnt[k] == $past(cnt[k])) ||
                    ($past(out_sig[k]) && !$past(out_sig[k], 2) && $past(gate))));
  end

endmodule

bind plu_scaler plu_scaler_chk #(
  .NUM_OUT(NUM_OUT),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate     (gate),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .out_sig  (out_sig),
  .cnt      (cnt_arr)
);

// File: tb/plu_scaler_test.sv
`timescale 1ns/1ps
module plu_scaler_test;

  localparam int AD_INV  = 16;
  localparam int AD_CTRL = 17;
  localparam int AD_OR   = 8;
  localparam int AD_CNT  = 24;

  logic        clk;
  logic        rst_n;
  logic [15:0] in_v;
  logic        gate_v;
  logic        wr_v;
  logic [4:0]  addr_v;
  logic [31:0] wdata_v;
  logic [31:0] rdata;
  logic [31:0] rdata_n;
  logic [7:0]  out_v;
  logic [7:0]  out_n;

  int tests;
  int fails;
  bit done;

  plu_scaler uut (
    .clk(clk), .rst_n(rst_n), .in_sig(in_v), .gate(gate_v),
    .bus_wr(wr_v), .bus_addr(addr_v), .bus_wdata(wdata_v),
    .bus_rdata(rdata), .out_sig(out_v)
  );

  plu_scaler #(.CNT_W(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .in_sig(in_v), .gate(gate_v),
    .bus_wr(wr_v), .bus_addr(addr_v), .bus_wdata(wdata_v),
    .bus_rdata(rdata_n), .out_sig(out_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_v = 1'b1; addr_v = 5'(a); wdata_v = d;
    @(negedge clk);
    wr_v = 1'b0; wdata_v = '0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk);
    addr_v = 5'(a);
    @(negedge clk);
    d = rdata; dn = rdata_n;
  endtask

  task automatic set_in(input logic [15:0] v);
    @(negedge clk);
    in_v = v;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_v = 16'h0001;
      repeat (2) @(negedge clk);
      in_v = 16'h0000;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < 8; k++) begin
      bus_write(k, 0);
      bus_write(AD_OR + k, 0);
    end
    bus_write(AD_INV, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d, dn;
    check("R1", "out after reset", 32'(out_v), 0);
    bus_read(0, d, dn);       check("R1", "and mask 0", d, 0);
    bus_read(AD_OR + 7, d, dn); check("R1", "or mask 7", d, 0);
    bus_read(AD_INV, d, dn);  check("R1", "invert reg", d, 0);
    bus_read(AD_CNT + 3, d, dn); check("R1", "scaler 3", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d, dn;
    bus_write(3, 32'h0000_A5A5);
    bus_write(AD_OR + 5, 32'h0000_1234);
    bus_write(0, 32'hFFFF_ABCD);
    bus_read(3, d, dn);        check("R6", "and mask 3", d, 32'h0000_A5A5);
    bus_read(AD_OR + 5, d, dn); check("R6", "or mask 5", d, 32'h0000_1234);
    bus_read(0, d, dn);        check("R6", "and mask 0 upper bits", d, 32'h0000_ABCD);
    bus_write(AD_INV, 32'hFFFF_FF00);
    bus_read(AD_INV, d, dn);   check("R6", "invert reg upper bits", d, 32'h0000_0000);
    bus_write(AD_CNT + 2, 32'hFFFF_FFFF);
    bus_read(AD_CNT + 2, d, dn); check("R12", "write to scaler ignored", d, 0);
    clear_cfg();
  endtask

  task automatic t_and();
    bus_write(0, 32'h0003);
    @(negedge clk); in_v = 16'h0003;
    check("R11", "out before edge", 32'(out_v[0]), 0);
    @(negedge clk);
    check("R11", "out one clock later", 32'(out_v[0]), 1);
    check("R2", "all AND inputs high", 32'(out_v[0]), 1);
    set_in(16'h0001); check("R2", "one AND input low", 32'(out_v[0]), 0);
    set_in(16'hFFFF); check("R2", "zero AND mask output 1", 32'(out_v[1]), 0);
    clear_cfg();
    set_in(16'h0000);
  endtask

  task automatic t_or();
    bus_write(AD_OR + 2, 32'h0300);
    set_in(16'h0100); check("R3", "one OR input high", 32'(out_v[2]), 1);
    set_in(16'h0400); check("R3", "unselected input", 32'(out_v[2]), 0);
    set_in(16'h0000); check("R3", "no input", 32'(out_v[2]), 0);
    clear_cfg();
  endtask

  task automatic t_combo();
    bus_write(4, 32'h000C);
    bus_write(AD_OR + 4, 32'h8000);
    set_in(16'h8000); check("R4", "OR term alone", 32'(out_v[4]), 1);
    set_in(16'h000C); check("R4", "AND term alone", 32'(out_v[4]), 1);
    set_in(16'h0004); check("R4", "neither term", 32'(out_v[4]), 0);
    clear_cfg();
    set_in(16'h0000);
  endtask

  task automatic t_invert();
    bus_write(AD_INV, 32'h40);
    @(negedge clk);
    check("R5", "inverted idle output", 32'(out_v), 32'h40);
    bus_write(AD_OR + 6, 32'h0001);
    set_in(16'h0001); check("R5", "inverted active output", 32'(out_v[6]), 0);
    clear_cfg();
    set_in(16'h0000);
  endtask

  task automatic t_count();
    logic [31:0] d, dn;
    gate_v = 1'b1;
    bus_write(AD_CTRL, 1);
    bus_write(AD_OR + 0, 32'h0001);
    pulse(5);
    bus_read(AD_CNT + 0, d, dn); check("R7", "five edges", d, 5);
    bus_read(AD_CNT + 1, d, dn); check("R7", "other scaler idle", d, 0);
    @(negedge clk); in_v = 16'h0001;
    repeat (10) @(negedge clk);
    in_v = 16'h0000;
    repeat (2) @(negedge clk);
    bus_read(AD_CNT + 0, d, dn); check("R7", "held level counts once", d, 6);
  endtask

  task automatic t_gate();
    logic [31:0] d, dn;
    @(negedge clk); gate_v = 1'b0;
    pulse(3);
    bus_read(AD_CNT + 0, d, dn); check("R8", "gate low no count", d, 6);
    @(negedge clk); gate_v = 1'b1;
    pulse(1);
    bus_read(AD_CNT + 0, d, dn); check("R8", "gate restored counts", d, 7);
  endtask

  task automatic t_clear();
    logic [31:0] d, dn;
    bus_write(AD_CTRL, 1);
    bus_read(AD_CNT + 0, d, dn); check("R9", "clear zeroes", d, 0);
    // raise input so the output edge registers in the same clock as the clear
    @(negedge clk); in_v = 16'h0001;
    @(negedge clk);
    wr_v = 1'b1; addr_v = 5'(AD_CTRL); wdata_v = 32'h1;
    @(negedge clk);
    wr_v = 1'b0; wdata_v = '0;
    in_v = 16'h0000;
    repeat (2) @(negedge clk);
    bus_read(AD_CNT + 0, d, dn); check("R9", "clear beats coincident edge", d, 0);
    pulse(1);
    bus_read(AD_CNT + 0, d, dn); check("R9", "counting after clear", d, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d, dn;
    bus_write(AD_CTRL, 1);
    pulse(17);
    bus_read(AD_CNT + 0, d, dn);
    check("R10", "wide scaler", d, 17);
    check("R10", "narrow scaler wraps", dn, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; in_v = '0; gate_v = 1'b0;
    wr_v = 1'b0; addr_v = '0; wdata_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_and();
    t_or();
    t_combo();
    t_invert();
    t_count();
    t_gate();
    t_clear();
    t_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule